// File: doc/BRIEF.md
# Instruction Fetch Patch Unit

This block sits between a processor's instruction and literal fetch path and its code memory. Software loads a small bank of address comparators, a remap table base and a global enable. Each accepted fetch presents a word address and the word the code memory returned. If the unit is enabled and an enabled comparator watches that word, the returned data can be swapped for a word read from a table in RAM. The table entry is chosen by the number of the comparator that matched. Patch settings are cleared only by power-on reset, so they survive watchdog and other system resets.

The fetch path runs one request at a time through a small state machine. `ST_IDLE` accepts a request (`fetch_ready_o` high) and captures the address decision and the code word. It moves to `ST_ISSUE` on a remap hit, or to `ST_DONE` otherwise (pass through). `ST_ISSUE` raises `tbl_req_o` for one cycle and moves to `ST_WAIT`. `ST_WAIT` holds until `tbl_rvalid_i`, takes the table word and moves to `ST_DONE`. `ST_DONE` presents `fetch_rvalid_o` for one cycle and returns to `ST_IDLE`. A comparator whose replace field is non-zero substitutes nothing. It raises `fetch_flag_o` alongside the response.

Registers are selected by word index `reg_addr_i[REG_AW-1:2]`:
- byte offset 0x0: control
- byte offset 0x4: table base
- byte offset 0x8 + 4·n: comparator n

Top module: `fetch_patch_unit`

## Requirements
- R1: When the global enable is 0, or no enabled comparator watches the fetched word, the response carries `fetch_code_i` unchanged with `fetch_flag_o` low.
- R2: On a remap hit, `tbl_req_o` is high for exactly the one cycle after acceptance. `tbl_addr_o` equals table base + 4·n, where n is the matching comparator. The response, one cycle after `tbl_rvalid_i`, carries `tbl_rdata_i`.
- R3: When several enabled comparators watch the same word, the lowest-numbered one decides both the table entry and the replace behaviour.
- R4: Only fetch addresses with bits [31:29] = 000 can match. Comparison uses bits [28:2], so the byte offset bits [1:0] are ignored.
- R5: Comparator register layout: bit 0 is enable, bits [28:2] are the word address, and bits [31:30] are the replace field. Bits 29 and 1 read as 0. A comparator with enable 0 never matches.
- R6: A match whose winning comparator has a replace field other than 00 returns `fetch_code_i` unchanged, reads no table, and raises `fetch_flag_o` together with `fetch_rvalid_o`.
- R7: Control register (offset 0x0) bit 0 is the global enable and reads back in bit 0. A write changes it only if bit 1 of the written data is 1.
- R8: The table base register (offset 0x4) stores bits [28:2]. It reads back with bits [31:29] = 001 and [1:0] = 00, so the table always lies in 0x20000000–0x3FFFFFFF.
- R9: Register offsets: control 0x0, base 0x4, comparator n at 0x8 + 4·n. Offsets with no register read as 0.
- R10: `por_n` low clears enable, base and comparators. `sys_rst_n` low returns the fetch state machine to `ST_IDLE` but keeps all configuration.
- R11: One fetch at a time: `fetch_ready_o` is high only in `ST_IDLE` and is low while a response is pending or presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears configuration |
| sys_rst_n | input | 1 | System reset, active low, fetch path only |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW (5) | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_code_i | input | 32 | Word returned by code memory for this fetch |
| fetch_ready_o | output | 1 | Unit can accept a fetch |
| fetch_rvalid_o | output | 1 | Response valid |
| fetch_rdata_o | output | 32 | Response word (original or substituted) |
| fetch_flag_o | output | 1 | Match with non-remap replace field |
| tbl_req_o | output | 1 | Table read request |
| tbl_addr_o | output | 32 | Table read byte address |
| tbl_rvalid_i | input | 1 | Table read data valid |
| tbl_rdata_i | input | 32 | Table read data |

## Verification
On every cycle, the assertions check the following:
- a table read address always falls in the RAM window and is word aligned;
- a table request lasts one cycle;
- fetches outside the code region, or with the unit disabled, never reach the table;
- the flag only accompanies a response;
- the response never overlaps readiness;
- the global enable moves only on a keyed control write.

Only the bench scenarios can show the value-level behaviour. This covers the table word picked for each comparator, lowest-index priority, byte-offset insensitivity, pass-through data, register readback layout, and configuration surviving a system reset but not a power-on reset.

// File: rtl/fpatch_pkg.sv
package fpatch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fetch_state_e;

    typedef struct packed {
        logic [1:0]  replace;
        logic [26:0] word_addr;
        logic        enable;
    } cmp_cfg_t;

    localparam logic [2:0] CODE_REGION = 3'b000;
    localparam logic [2:0] RAM_REGION  = 3'b001;

endpackage

// File: rtl/fpatch_regs.sv
module fpatch_regs
    import fpatch_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int REG_AW  = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              glb_en,
    output logic [26:0]       tbl_base,
    output cmp_cfg_t          cmp [NUM_CMP]
);
    localparam int IW = REG_AW - 2;

    logic [IW-1:0] idx;
    logic          en_q;
    logic [26:0]   base_q;
    cmp_cfg_t      cmp_q [NUM_CMP];
    logic          unused_bits;

    assign idx         = addr[REG_AW-1:2];
    assign unused_bits = ^{addr[1:0], wdata[29]};

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
        end else if (we) begin
            if (idx == IW'(0) && wdata[1]) en_q <= wdata[0];
            if (idx == IW'(1)) base_q <= wdata[28:2];
        end
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                cmp_q[g] <= '0;
            end else if (we && idx == IW'(g + 2)) begin
                cmp_q[g] <= '{replace: wdata[31:30], word_addr: wdata[28:2], enable: wdata[0]};
            end
        end
        assign cmp[g] = cmp_q[g];
    end

    always_comb begin
        rdata = '0;
        if (idx == IW'(0)) rdata = {31'b0, en_q};
        if (idx == IW'(1)) rdata = {RAM_REGION, base_q, 2'b00};
        for (int i = 0; i < NUM_CMP; i++) begin
            if (idx == IW'(i + 2))
                rdata = {cmp_q[i].replace, 1'b0, cmp_q[i].word_addr, 1'b0, cmp_q[i].enable};
        end
    end

    assign glb_en   = en_q;
    assign tbl_base = base_q;

endmodule

// File: rtl/fpatch_match.sv
module fpatch_match
    import fpatch_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int IDXW    = 2
) (
    input  logic [31:0]     addr,
    input  logic            glb_en,
    input  cmp_cfg_t        cmp [NUM_CMP],
    output logic            hit,
    output logic [IDXW-1:0] hit_idx,
    output logic [1:0]      hit_replace
);
    logic [NUM_CMP-1:0] hit_vec;
    logic               in_code;
    logic               unused_bits;

    assign in_code     = (addr[31:29] == CODE_REGION);
    assign unused_bits = ^addr[1:0];

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign hit_vec[g] = glb_en && in_code && cmp[g].enable
                            && (cmp[g].word_addr == addr[28:2]);
    end

    // Walk from the top so the lowest index is written last and wins.
    always_comb begin
        hit         = 1'b0;
        hit_idx     = '0;
        hit_replace = '0;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit         = 1'b1;
                hit_idx     = IDXW'(i);
                hit_replace = cmp[i].replace;
            end
        end
    end

endmodule

// File: rtl/fpatch_seq.sv
module fpatch_seq
    import fpatch_pkg::*;
#(
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_req_i,
    input  logic [31:0]     fetch_code_i,
    input  logic            hit,
    input  logic [IDXW-1:0] hit_idx,
    input  logic [1:0]      hit_replace,
    input  logic [26:0]     tbl_base,
    input  logic            tbl_rvalid_i,
    input  logic [31:0]     tbl_rdata_i,
    output logic            fetch_ready_o,
    output logic            fetch_rvalid_o,
    output logic [31:0]     fetch_rdata_o,
    output logic            fetch_flag_o,
    output logic            tbl_req_o,
    output logic [31:0]     tbl_addr_o
);
    fetch_state_e state_q, state_d;
    logic [31:0]  data_q;
    logic         flag_q;
    logic [26:0]  slot_q;
    logic         remap_go;

    assign remap_go = hit && (hit_replace == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fetch_req_i) state_d = remap_go ? ST_ISSUE : ST_DONE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (tbl_rvalid_i) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            flag_q <= 1'b0;
            slot_q <= '0;
        end else if (state_q == ST_IDLE && fetch_req_i) begin
            data_q <= fetch_code_i;
            flag_q <= hit && (hit_replace != 2'b00);
            slot_q <= tbl_base + 27'(hit_idx);
        end else if (state_q == ST_WAIT && tbl_rvalid_i) begin
            data_q <= tbl_rdata_i;
        end
    end

    always_comb begin
        fetch_ready_o  = 1'b0;
        fetch_rvalid_o = 1'b0;
        fetch_rdata_o  = '0;
        fetch_flag_o   = 1'b0;
        tbl_req_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  fetch_ready_o = 1'b1;
            ST_ISSUE: tbl_req_o = 1'b1;
            ST_WAIT:  ;
            ST_DONE: begin
                fetch_rvalid_o = 1'b1;
                fetch_rdata_o  = data_q;
                fetch_flag_o   = flag_q;
            end
        endcase
    end

    assign tbl_addr_o = {RAM_REGION, slot_q, 2'b00};

endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
    import fpatch_pkg::*;
#(
    parameter  int NUM_CMP = 4,
    localparam int REG_AW  = $clog2((NUM_CMP + 2) * 4),
    localparam int IDXW    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              fetch_req_i,
    input  logic [31:0]       fetch_addr_i,
    input  logic [31:0]       fetch_code_i,
    output logic              fetch_ready_o,
    output logic              fetch_rvalid_o,
    output logic [31:0]       fetch_rdata_o,
    output logic              fetch_flag_o,
    output logic              tbl_req_o,
    output logic [31:0]       tbl_addr_o,
    input  logic              tbl_rvalid_i,
    input  logic [31:0]       tbl_rdata_i
);
    logic            glb_en;
    logic [26:0]     tbl_base;
    cmp_cfg_t        cmp [NUM_CMP];
    logic            hit;
    logic [IDXW-1:0] hit_idx;
    logic [1:0]      hit_replace;
    logic            seq_rst_n;

    assign seq_rst_n = por_n & sys_rst_n;

    fpatch_regs #(.NUM_CMP(NUM_CMP), .REG_AW(REG_AW)) i_regs (
        .clk      (clk),
        .por_n    (por_n),
        .we       (reg_we_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .rdata    (reg_rdata_o),
        .glb_en   (glb_en),
        .tbl_base (tbl_base),
        .cmp      (cmp)
    );

    fpatch_match #(.NUM_CMP(NUM_CMP), .IDXW(IDXW)) i_match (
        .addr        (fetch_addr_i),
        .glb_en      (glb_en),
        .cmp         (cmp),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .hit_replace (hit_replace)
    );

    fpatch_seq #(.IDXW(IDXW)) i_seq (
        .clk            (clk),
        .rst_n          (seq_rst_n),
        .fetch_req_i    (fetch_req_i),
        .fetch_code_i   (fetch_code_i),
        .hit            (hit),
        .hit_idx        (hit_idx),
        .hit_replace    (hit_replace),
        .tbl_base       (tbl_base),
        .tbl_rvalid_i   (tbl_rvalid_i),
        .tbl_rdata_i    (tbl_rdata_i),
        .fetch_ready_o  (fetch_ready_o),
        .fetch_rvalid_o (fetch_rvalid_o),
        .fetch_rdata_o  (fetch_rdata_o),
        .fetch_flag_o   (fetch_flag_o),
        .tbl_req_o      (tbl_req_o),
        .tbl_addr_o     (tbl_addr_o)
    );

endmodule

// File: rtl/fpatch_chk.sv
module fpatch_chk #(
    parameter int IW = 3
) (
    input logic          clk,
    input logic          por_n,
    input logic          sys_rst_n,
    input logic          reg_we_i,
    input logic [IW-1:0] reg_idx,
    input logic          reg_key,
    input logic          fetch_req_i,
    input logic [2:0]    fetch_region,
    input logic          fetch_ready_o,
    input logic          fetch_rvalid_o,
    input logic          fetch_flag_o,
    input logic          tbl_req_o,
    input logic [2:0]    tbl_hi,
    input logic [1:0]    tbl_lo,
    input logic          glb_en
);
    // R8: any table read lands in the RAM window on a word boundary
    p_tbl_window_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        tbl_req_o |-> (tbl_hi == 3'b001 && tbl_lo == 2'b00));

    // R2: table request lasts a single cycle
    p_tbl_single_r2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        tbl_req_o |=> !tbl_req_o);

    // R4: fetches outside the code region never read the table
    p_outside_no_tbl_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (fetch_req_i && fetch_ready_o && fetch_region != 3'b000) |=> !tbl_req_o);

    // R1: disabled unit never reads the table
    p_disabled_no_tbl_r1: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (fetch_req_i && fetch_ready_o && !glb_en) |=> !tbl_req_o);

    // R6: flag only accompanies a response
    p_flag_with_resp_r6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        fetch_flag_o |-> fetch_rvalid_o);

    // R11: response and readiness never overlap
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        fetch_rvalid_o |-> !fetch_ready_o);

    // R7, R10: enable changes only through a keyed control write
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        !(reg_we_i && reg_idx == '0 && reg_key) |=> $stable(glb_en));

endmodule

bind fetch_patch_unit fpatch_chk #(.IW(REG_AW - 2)) i_chk (
    .clk            (clk),
    .por_n          (por_n),
    .sys_rst_n      (sys_rst_n),
    .reg_we_i       (reg_we_i),
    .reg_idx        (reg_addr_i[REG_AW-1:2]),
    .reg_key        (reg_wdata_i[1]),
    .fetch_req_i    (fetch_req_i),
    .fetch_region   (fetch_addr_i[31:29]),
    .fetch_ready_o  (fetch_ready_o),
    .fetch_rvalid_o (fetch_rvalid_o),
    .fetch_flag_o   (fetch_flag_o),
    .tbl_req_o      (tbl_req_o),
    .tbl_hi         (tbl_addr_o[31:29]),
    .tbl_lo         (tbl_addr_o[1:0]),
    .glb_en         (glb_en)
);

// File: tb/test_fetch_patch_unit.sv
module test_fetch_patch_unit;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] fetch_code = '0;
    logic        fetch_ready, fetch_rvalid, fetch_flag;
    logic [31:0] fetch_rdata;
    logic        tbl_req;
    logic [31:0] tbl_addr;
    logic        tbl_rvalid = 1'b0;
    logic [31:0] tbl_rdata = '0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    fetch_patch_unit i_fetch_patch_unit (
        .clk            (clk),
        .por_n          (por_n),
        .sys_rst_n      (sys_rst_n),
        .reg_we_i       (reg_we),
        .reg_addr_i     (reg_addr),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .fetch_req_i    (fetch_req),
        .fetch_addr_i   (fetch_addr),
        .fetch_code_i   (fetch_code),
        .fetch_ready_o  (fetch_ready),
        .fetch_rvalid_o (fetch_rvalid),
        .fetch_rdata_o  (fetch_rdata),
        .fetch_flag_o   (fetch_flag),
        .tbl_req_o      (tbl_req),
        .tbl_addr_o     (tbl_addr),
        .tbl_rvalid_i   (tbl_rvalid),
        .tbl_rdata_i    (tbl_rdata)
    );

    function automatic logic [31:0] tfn(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // RAM model: answers a table read a few cycles later with tfn(address)
    logic        pend = 1'b0;
    int          cnt  = 0;
    logic [31:0] paddr = '0;
    always @(posedge clk) begin
        if (tbl_req) begin
            pend <= 1'b1; cnt <= 2; paddr <= tbl_addr; tbl_rvalid <= 1'b0;
        end else if (pend && cnt == 0) begin
            tbl_rvalid <= 1'b1; tbl_rdata <= tfn(paddr); pend <= 1'b0;
        end else begin
            tbl_rvalid <= 1'b0;
            if (pend) cnt <= cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] data;
        logic        flag;
        string       req;
    } exp_t;
    exp_t sb[$];

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (fetch_rvalid && por_n && sys_rst_n) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected response", fetch_rdata, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(fetch_rdata == e.data, e.req, fetch_rdata, e.data);
                chk(fetch_flag == e.flag, {e.req, " flag"}, {31'b0, fetch_flag}, {31'b0, e.flag});
            end
        end
    end

    task automatic reg_wr(input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] off, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = off;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic do_fetch(input logic [31:0] a, input logic [31:0] code,
                            input logic [31:0] exp_d, input logic exp_f,
                            input logic exp_tbl, input string req);
        exp_t e;
        @(negedge clk);
        while (!fetch_ready) @(negedge clk);
        e.data = exp_d; e.flag = exp_f; e.req = req;
        sb.push_back(e);
        fetch_req = 1'b1; fetch_addr = a; fetch_code = code;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(!fetch_ready, "R11 ready low after accept", {31'b0, fetch_ready}, 32'h0);
        chk(tbl_req == exp_tbl, "R2 table request timing", {31'b0, tbl_req}, {31'b0, exp_tbl});
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; sys_rst_n = 1'b1;
        #1;
        chk(fetch_ready == 1'b1, "R10 ready after reset", {31'b0, fetch_ready}, 32'h1);
        chk(fetch_rvalid == 1'b0, "R10 no response after reset", {31'b0, fetch_rvalid}, 32'h0);
        reg_rd(5'h00, 32'h0, "R10 control reset");
        reg_rd(5'h04, 32'h2000_0000, "R8 base reset");
        reg_rd(5'h08, 32'h0, "R10 comparator reset");

        do_fetch(32'h0800_5418, 32'h1111_1111, 32'h1111_1111, 1'b0, 1'b0, "R1 disabled pass");

        reg_wr(5'h04, 32'hFFFF_FF83);
        reg_rd(5'h04, 32'h3FFF_FF80, "R8 base window");
        reg_wr(5'h04, 32'h2000_0180);
        reg_rd(5'h04, 32'h2000_0180, "R9 base offset");

        reg_wr(5'h14, 32'hFFFF_FFFF);
        reg_rd(5'h14, 32'hDFFF_FFFD, "R5 comparator layout");
        reg_wr(5'h14, 32'h4000_0201);
        reg_wr(5'h08, 32'h0800_5419);
        reg_wr(5'h0C, 32'h0800_0EF1);
        reg_wr(5'h10, 32'h4800_0EF1);
        reg_rd(5'h08, 32'h0800_5419, "R9 comparator 0 offset");
        reg_rd(5'h10, 32'h4800_0EF1, "R9 comparator 2 offset");
        reg_rd(5'h18, 32'h0, "R9 unmapped offset");
        reg_rd(5'h1C, 32'h0, "R9 unmapped offset top");

        reg_wr(5'h00, 32'h0000_0001);
        reg_rd(5'h00, 32'h0, "R7 no key ignored");
        do_fetch(32'h0800_5418, 32'hAAAA_5555, 32'hAAAA_5555, 1'b0, 1'b0, "R7 still disabled");
        reg_wr(5'h00, 32'h0000_0003);
        reg_rd(5'h00, 32'h1, "R7 keyed enable");

        do_fetch(32'h0800_5418, 32'h1234_5678, tfn(32'h2000_0180), 1'b0, 1'b1, "R2 remap slot 0");
        do_fetch(32'h0800_541A, 32'h1234_5678, tfn(32'h2000_0180), 1'b0, 1'b1, "R4 byte offset ignored");
        do_fetch(32'h0800_0EF0, 32'h5555_0EF0, tfn(32'h2000_0184), 1'b0, 1'b1, "R3 lowest index wins");
        do_fetch(32'h2800_5418, 32'h7777_8888, 32'h7777_8888, 1'b0, 1'b0, "R4 outside code region");
        do_fetch(32'h0000_0200, 32'hCAFE_0200, 32'hCAFE_0200, 1'b1, 1'b0, "R6 replace flag only");
        do_fetch(32'h0000_0300, 32'h0BAD_0300, 32'h0BAD_0300, 1'b0, 1'b0, "R1 no match pass");

        reg_wr(5'h0C, 32'h0800_0EF0);
        do_fetch(32'h0800_0EF0, 32'hBEEF_0EF0, 32'hBEEF_0EF0, 1'b1, 1'b0, "R5 disabled comparator skipped");

        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        reg_rd(5'h00, 32'h1, "R10 enable kept over system reset");
        reg_rd(5'h08, 32'h0800_5419, "R10 comparator kept");
        reg_rd(5'h04, 32'h2000_0180, "R10 base kept");
        do_fetch(32'h0800_5418, 32'h0, tfn(32'h2000_0180), 1'b0, 1'b1, "R10 remap after system reset");

        reg_wr(5'h00, 32'h0000_0002);
        reg_rd(5'h00, 32'h0, "R7 keyed disable");
        do_fetch(32'h0800_5418, 32'h3333_4444, 32'h3333_4444, 1'b0, 1'b0, "R1 disabled after clear");

        reg_wr(5'h00, 32'h0000_0003);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        reg_rd(5'h00, 32'h0, "R10 power-on clears enable");
        reg_rd(5'h04, 32'h2000_0000, "R10 power-on clears base");
        reg_rd(5'h08, 32'h0, "R10 power-on clears comparator");

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule